// File: doc/BRIEF.md
# Multi-FIFO Slave Port

This block lets an external bus master move data in and out of four internal packet FIFOs through one shared set of pins. A two-bit address picks the FIFO that the shared strobes and data bus act on. Each FIFO has a fixed direction:

- An IN FIFO is filled from the external port and drained by the internal side.
- An OUT FIFO is filled by the internal side and drained from the external port.

Each FIFO can be set to an 8-bit or a 16-bit external width. The four control strobes are read, write, output enable and packet commit. The status flags sent to the pins are empty, almost empty, full and almost full. Each strobe and the flag outputs have a programmable polarity.

The internal side has a plain push/pop interface for each FIFO. A packet commit on an IN FIFO sends a one-cycle ready pulse to the internal side, with the byte count the FIFO holds. This lets a short packet leave before the FIFO is full. A commit on an empty IN FIFO signals a zero-length packet. A status word gives the flag state and the sticky error bits of all four FIFOs at once, whichever FIFO is addressed.

Top module: `slave_fifo_port`

## Requirements
- R1: `ext_addr` selects the FIFO. An active write pushes `ext_din` into the selected FIFO only if it is an IN FIFO (`cfg_dir_in` bit = 1). An active read pops the selected FIFO only if it is an OUT FIFO (bit = 0).
- R2: Strobes that do not match a FIFO's direction are ignored. These are an external read of an IN FIFO, an external write to an OUT FIFO, `usb_push` on an IN FIFO and `usb_pop` on an OUT FIFO.
- R3: `cfg_strobe_hi` sets the active level of each strobe: bit0 read, bit1 write, bit2 output enable, bit3 commit. A bit of 1 means active-high and 0 means active-low.
- R4: The four `ext_*` flag outputs show the selected FIFO's flags. They are active-high when `cfg_flag_hi` = 1 and inverted when it is 0.
- R5: In a FIFO with `cfg_wide` bit = 0, only the low byte of the pushed word is stored, so the upper byte reads back as zero on `ext_dout` and `usb_rdata`.
- R6: Each FIFO holds 16 words. Its empty flag is set at 0 entries and its full flag at 16 entries.
- R7: Almost empty is set at exactly 1 entry, and almost full at exactly 15 entries.
- R8: A push into a full FIFO or a pop from an empty FIFO is ignored. It sets that FIFO's overflow or underflow bit, which stays set until reset.
- R9: The head word is shown before it is read (first-word fall-through). `ext_dout` equals the selected FIFO's head while output enable is active, and is zero when output enable is inactive or the FIFO is empty. `ext_dout_en` follows output enable.
- R10: A commit on the selected IN FIFO gives a `pkt_ready` pulse in the next cycle, with only that FIFO's bit set. `pkt_bytes` carries the FIFO's entry count before that edge, doubled in 16-bit mode. A commit on an OUT FIFO does nothing.
- R11: A commit on an empty IN FIFO reports `pkt_zero` = 1 with `pkt_bytes` = 0.
- R12: `stat_flags` holds 6 bits per FIFO, with FIFO i at bits [6i+5:6i]. The bit order, from bit 0 up, is empty, almost empty, full, almost full, overflow, underflow. The word always covers all four FIFOs.
- R13: Strobes take effect at the rising clock edge, and all flags show the new occupancy in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_in | input | 4 | Per-FIFO direction, 1 = IN (external write side) |
| cfg_wide | input | 4 | Per-FIFO width, 1 = 16-bit, 0 = 8-bit |
| cfg_strobe_hi | input | 4 | Strobe polarity: read, write, output enable, commit |
| cfg_flag_hi | input | 1 | Flag output polarity, 1 = active-high |
| ext_addr | input | 2 | FIFO select |
| ext_rd | input | 1 | Read strobe |
| ext_wr | input | 1 | Write strobe |
| ext_oe | input | 1 | Output enable |
| ext_commit | input | 1 | Packet commit strobe |
| ext_din | input | 16 | Write data |
| ext_dout | output | 16 | Read data of the selected FIFO |
| ext_dout_en | output | 1 | High while read data is driven |
| ext_empty | output | 1 | Selected FIFO empty |
| ext_almost_empty | output | 1 | Selected FIFO holds one entry |
| ext_full | output | 1 | Selected FIFO full |
| ext_almost_full | output | 1 | Selected FIFO has one free slot |
| usb_push | input | 4 | Internal push, one bit per FIFO |
| usb_pop | input | 4 | Internal pop, one bit per FIFO |
| usb_wdata | input | 16 | Internal push data |
| usb_rdata | output | 64 | Head word of each FIFO, 16 bits per FIFO |
| pkt_ready | output | 4 | One-cycle commit pulse per FIFO |
| pkt_bytes | output | 6 | Byte count of the last commit |
| pkt_zero | output | 1 | Last commit was zero-length |
| stat_flags | output | 24 | Status word of all FIFOs |

## Verification
The embedded assertions check these rules on every cycle:

- Occupancy never goes past 16.
- The overflow and underflow bits stay set once set.
- A push into a full FIFO leaves it full.
- Read data is zero while output enable is inactive.
- At most one commit pulse is active.
- A zero-length report carries a zero byte count.

Only the bench scenarios can show the rest, by comparing with a reference model: data order through each FIFO, masking in narrow mode, rejection of strobes in the wrong direction, the effect of both polarity settings, and the exact byte count and cycle of each commit.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int unsigned NFIFO = 4;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned DW    = 16;
    localparam int unsigned AW    = $clog2(NFIFO);
    localparam int unsigned PW    = $clog2(DEPTH);
    localparam int unsigned CW    = $clog2(DEPTH + 1);
    localparam int unsigned BW    = CW + 1;
    localparam int unsigned HW    = DW / 2;

    // strobe indices inside the polarity/strobe vectors
    localparam int unsigned STB_RD     = 0;
    localparam int unsigned STB_WR     = 1;
    localparam int unsigned STB_OE     = 2;
    localparam int unsigned STB_COMMIT = 3;
    localparam int unsigned NSTB       = 4;

    typedef struct packed {
        logic underflow;
        logic overflow;
        logic almost_full;
        logic full;
        logic almost_empty;
        logic empty;
    } fifo_stat_t;

    localparam int unsigned SW = $bits(fifo_stat_t);

    function automatic logic active_of(input logic raw, input logic hi);
        return hi ? raw : ~raw;
    endfunction

    function automatic logic [BW-1:0] byte_count(input logic [CW-1:0] cnt, input logic wide);
        return wide ? {cnt, 1'b0} : BW'(cnt);
    endfunction
endpackage

// File: rtl/sfp_strobe_decode.sv
module sfp_strobe_decode
    import sfp_pkg::*;
(
    input  logic [NSTB-1:0] raw,
    input  logic [NSTB-1:0] hi,
    output logic [NSTB-1:0] act
);
    for (genvar s = 0; s < NSTB; s++) begin : g_stb
        assign act[s] = active_of(raw[s], hi[s]);
    end
endmodule

// File: rtl/sfp_fifo.sv
module sfp_fifo
    import sfp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wide,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output fifo_stat_t    stat
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          ovf, udf;
    logic          push_ok, pop_ok;
    logic [DW-1:0] store;

    assign push_ok = push && (cnt != CW'(DEPTH));
    assign pop_ok  = pop && (cnt != '0);
    assign store   = wide ? wdata : {{(DW-HW){1'b0}}, wdata[HW-1:0]};

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= store;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
            if (push && !push_ok) ovf <= 1'b1;
            if (pop && !pop_ok)   udf <= 1'b1;
        end
    end

    assign head  = (cnt == '0) ? '0 : mem[rd_ptr];
    assign count = cnt;

    always_comb begin
        stat.empty        = (cnt == '0);
        stat.almost_empty = (cnt == CW'(1));
        stat.full         = (cnt == CW'(DEPTH));
        stat.almost_full  = (cnt == CW'(DEPTH-1));
        stat.overflow     = ovf;
        stat.underflow    = udf;
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R8
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst) udf |=> udf); // R8
    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        (stat.full && push && !pop) |=> stat.full && ovf); // R8
endmodule

// File: rtl/sfp_pkt_commit.sv
module sfp_pkt_commit
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [AW-1:0]    sel,
    input  logic [CW-1:0]    cnt,
    input  logic             wide,
    output logic [NFIFO-1:0] ready,
    output logic [BW-1:0]    bytes,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= '0;
            bytes <= '0;
            zero  <= 1'b0;
        end else begin
            ready <= fire ? (NFIFO'(1) << sel) : '0;
            if (fire) begin
                bytes <= byte_count(cnt, wide);
                zero  <= (cnt == '0);
            end
        end
    end

    AST_PKT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ready)); // R10
    AST_ZERO_BYTES: assert property (@(posedge clk) disable iff (rst)
        (ready != '0 && zero) |-> bytes == '0); // R11
endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port
    import sfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NFIFO-1:0]    cfg_dir_in,
    input  logic [NFIFO-1:0]    cfg_wide,
    input  logic [NSTB-1:0]     cfg_strobe_hi,
    input  logic                cfg_flag_hi,
    input  logic [AW-1:0]       ext_addr,
    input  logic                ext_rd,
    input  logic                ext_wr,
    input  logic                ext_oe,
    input  logic                ext_commit,
    input  logic [DW-1:0]       ext_din,
    output logic [DW-1:0]       ext_dout,
    output logic                ext_dout_en,
    output logic                ext_empty,
    output logic                ext_almost_empty,
    output logic                ext_full,
    output logic                ext_almost_full,
    input  logic [NFIFO-1:0]    usb_push,
    input  logic [NFIFO-1:0]    usb_pop,
    input  logic [DW-1:0]       usb_wdata,
    output logic [NFIFO*DW-1:0] usb_rdata,
    output logic [NFIFO-1:0]    pkt_ready,
    output logic [BW-1:0]       pkt_bytes,
    output logic                pkt_zero,
    output logic [NFIFO*SW-1:0] stat_flags
);
    logic [NSTB-1:0]  stb_raw, stb_act;
    logic [NFIFO-1:0] push, pop;
    logic [DW-1:0]    wdat   [NFIFO];
    logic [DW-1:0]    heads  [NFIFO];
    logic [CW-1:0]    counts [NFIFO];
    fifo_stat_t       stats  [NFIFO];
    fifo_stat_t       sel_stat;
    logic             commit_fire;

    assign stb_raw[STB_RD]     = ext_rd;
    assign stb_raw[STB_WR]     = ext_wr;
    assign stb_raw[STB_OE]     = ext_oe;
    assign stb_raw[STB_COMMIT] = ext_commit;

    sfp_strobe_decode u_decode (
        .raw (stb_raw),
        .hi  (cfg_strobe_hi),
        .act (stb_act)
    );

    for (genvar i = 0; i < NFIFO; i++) begin : g_fifo
        logic addressed;
        assign addressed = (ext_addr == AW'(i));
        assign push[i] = cfg_dir_in[i] ? (stb_act[STB_WR] && addressed) : usb_push[i];
        assign pop[i]  = cfg_dir_in[i] ? usb_pop[i] : (stb_act[STB_RD] && addressed);
        assign wdat[i] = cfg_dir_in[i] ? ext_din : usb_wdata;

        sfp_fifo u_fifo (
            .clk   (clk),
            .rst   (rst),
            .wide  (cfg_wide[i]),
            .push  (push[i]),
            .pop   (pop[i]),
            .wdata (wdat[i]),
            .head  (heads[i]),
            .count (counts[i]),
            .stat  (stats[i])
        );

        assign usb_rdata[i*DW +: DW]  = heads[i];
        assign stat_flags[i*SW +: SW] = stats[i];
    end

    assign sel_stat         = stats[ext_addr];
    assign ext_empty        = active_of(sel_stat.empty, cfg_flag_hi);
    assign ext_almost_empty = active_of(sel_stat.almost_empty, cfg_flag_hi);
    assign ext_full         = active_of(sel_stat.full, cfg_flag_hi);
    assign ext_almost_full  = active_of(sel_stat.almost_full, cfg_flag_hi);

    assign ext_dout_en = stb_act[STB_OE];
    assign ext_dout    = stb_act[STB_OE] ? heads[ext_addr] : '0;

    assign commit_fire = stb_act[STB_COMMIT] && cfg_dir_in[ext_addr];

    sfp_pkt_commit u_commit (
        .clk   (clk),
        .rst   (rst),
        .fire  (commit_fire),
        .sel   (ext_addr),
        .cnt   (counts[ext_addr]),
        .wide  (cfg_wide[ext_addr]),
        .ready (pkt_ready),
        .bytes (pkt_bytes),
        .zero  (pkt_zero)
    );

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ext_dout_en |-> ext_dout == '0); // R9
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (commit_fire && pkt_ready == '0) |=> pkt_ready != '0); // R10
endmodule

// File: tb/slave_fifo_port_test.sv
module slave_fifo_port_test;
    import sfp_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [3:0]  cfg_dir_in, cfg_wide, cfg_strobe_hi;
    logic        cfg_flag_hi;
    logic [1:0]  ext_addr;
    logic        ext_rd, ext_wr, ext_oe, ext_commit;
    logic [15:0] ext_din, ext_dout, usb_wdata;
    logic        ext_dout_en, ext_empty, ext_almost_empty, ext_full, ext_almost_full;
    logic [3:0]  usb_push, usb_pop, pkt_ready;
    logic [63:0] usb_rdata;
    logic [5:0]  pkt_bytes;
    logic        pkt_zero;
    logic [23:0] stat_flags;

    slave_fifo_port uut (
        .clk(clk), .rst(rst), .cfg_dir_in(cfg_dir_in), .cfg_wide(cfg_wide),
        .cfg_strobe_hi(cfg_strobe_hi), .cfg_flag_hi(cfg_flag_hi), .ext_addr(ext_addr),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_oe(ext_oe), .ext_commit(ext_commit),
        .ext_din(ext_din), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
        .ext_empty(ext_empty), .ext_almost_empty(ext_almost_empty), .ext_full(ext_full),
        .ext_almost_full(ext_almost_full), .usb_push(usb_push), .usb_pop(usb_pop),
        .usb_wdata(usb_wdata), .usb_rdata(usb_rdata), .pkt_ready(pkt_ready),
        .pkt_bytes(pkt_bytes), .pkt_zero(pkt_zero), .stat_flags(stat_flags)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model
    logic [15:0] m_mem [4][16];
    int          m_head [4];
    int          m_cnt [4];
    bit          m_ovf [4];
    bit          m_udf [4];
    bit          e_pkt;
    int          e_sel, e_bytes;
    bit          e_zero;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_stat(input int i);
        return {m_udf[i], m_ovf[i], m_cnt[i] == 15, m_cnt[i] == 16, m_cnt[i] == 1, m_cnt[i] == 0};
    endfunction

    function automatic logic [15:0] exp_head(input int i);
        return (m_cnt[i] == 0) ? 16'h0 : m_mem[i][m_head[i]];
    endfunction

    function automatic logic pin(input logic act, input logic hi);
        return hi ? act : ~act;
    endfunction

    function automatic int bytes_of(input int cnt, input int i);
        return cfg_wide[i] ? cnt * 2 : cnt;
    endfunction

    // one interface cycle; strobes given as logical (active) values
    task automatic step(input int a, input bit rd, input bit wr, input bit oe, input bit cm,
                        input logic [15:0] din, input logic [3:0] up, input logic [3:0] upo,
                        input logic [15:0] uw);
        int pre [4];
        logic [23:0] es;
        logic [63:0] er;
        ext_addr   = 2'(a);
        ext_rd     = pin(rd, cfg_strobe_hi[0]);
        ext_wr     = pin(wr, cfg_strobe_hi[1]);
        ext_oe     = pin(oe, cfg_strobe_hi[2]);
        ext_commit = pin(cm, cfg_strobe_hi[3]);
        ext_din    = din;
        usb_push   = up;
        usb_pop    = upo;
        usb_wdata  = uw;
        for (int i = 0; i < 4; i++) pre[i] = m_cnt[i];
        e_pkt = cm && cfg_dir_in[a];   // R10: commit only on IN FIFO
        if (e_pkt) begin
            e_sel   = a;
            e_bytes = bytes_of(pre[a], a);
            e_zero  = (pre[a] == 0);
        end
        for (int i = 0; i < 4; i++) begin
            bit do_push, do_pop;
            logic [15:0] d;
            int tail;
            // R1/R2: direction decides which side may push or pop
            do_push = cfg_dir_in[i] ? (wr && a == i) : up[i];
            do_pop  = cfg_dir_in[i] ? upo[i] : (rd && a == i);
            d = cfg_dir_in[i] ? din : uw;
            if (!cfg_wide[i]) d = {8'h00, d[7:0]};   // R5
            tail = (m_head[i] + pre[i]) % 16;
            if (do_pop) begin
                if (pre[i] > 0) begin
                    m_head[i] = (m_head[i] + 1) % 16;
                    m_cnt[i]--;
                end else m_udf[i] = 1;
            end
            if (do_push) begin
                if (pre[i] < 16) begin
                    m_mem[i][tail] = d;
                    m_cnt[i]++;
                end else m_ovf[i] = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        es = '0;
        er = '0;
        for (int i = 0; i < 4; i++) begin
            es[i*6 +: 6]  = exp_stat(i);
            er[i*16 +: 16] = exp_head(i);
        end
        chk("R12 R6 R7 R8 R2 R13 stat_flags", 64'(stat_flags), 64'(es));
        chk("R4 R3 selected flags",
            64'({ext_empty, ext_almost_empty, ext_full, ext_almost_full}),
            64'({pin(m_cnt[a] == 0, cfg_flag_hi), pin(m_cnt[a] == 1, cfg_flag_hi),
                 pin(m_cnt[a] == 16, cfg_flag_hi), pin(m_cnt[a] == 15, cfg_flag_hi)}));
        chk("R9 R5 ext_dout", 64'({ext_dout_en, ext_dout}), 64'({oe, oe ? exp_head(a) : 16'h0}));
        chk("R1 R5 usb_rdata", usb_rdata, er);
        chk("R10 pkt_ready", 64'(pkt_ready), e_pkt ? 64'(1 << e_sel) : 64'h0);
        if (e_pkt) chk("R10 R11 pkt_bytes/zero", 64'({pkt_zero, pkt_bytes}), 64'({e_zero, 6'(e_bytes)}));
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 16'h0, 4'h0, 4'h0, 16'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            m_head[i] = 0; m_cnt[i] = 0; m_ovf[i] = 0; m_udf[i] = 0;
            for (int j = 0; j < 16; j++) m_mem[i][j] = 16'h0;
        end
        cfg_dir_in    = 4'b0011;   // FIFO0,1 IN; FIFO2,3 OUT
        cfg_wide      = 4'b0101;   // FIFO0,2 wide; FIFO1,3 narrow
        cfg_strobe_hi = 4'b0000;   // R3: all strobes active-low first
        cfg_flag_hi   = 1'b0;
        rst = 1'b1;
        ext_addr = 0; ext_rd = 1; ext_wr = 1; ext_oe = 1; ext_commit = 1;
        ext_din = 0; usb_push = 0; usb_pop = 0; usb_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R12 reset stat_flags", 64'(stat_flags), 64'h041041);
        chk("R4 reset flags active-low", 64'({ext_empty, ext_full}), 64'b01);
        idle();

        // R6 R7 R8: fill wide IN FIFO0, one write past full
        for (int k = 0; k < 17; k++) step(0, 0, 1, 1, 0, 16'(16'h1111 * (k + 1)), 4'h0, 4'h0, 16'h0);
        // R10: commit full wide FIFO -> 32 bytes
        step(0, 0, 0, 0, 1, 16'h0, 4'h0, 4'h0, 16'h0);
        idle();
        // R2: external read of IN FIFO ignored
        step(0, 1, 0, 1, 0, 16'h0, 4'h0, 4'h0, 16'h0);
        // R8: drain FIFO0 from internal side plus one extra pop
        for (int k = 0; k < 17; k++) step(0, 0, 0, 1, 0, 16'h0, 4'h0, 4'b0001, 16'h0);
        // R11: commit on empty narrow IN FIFO1
        step(1, 0, 0, 0, 1, 16'h0, 4'h0, 4'h0, 16'h0);
        // R5: narrow OUT FIFO3 gets internal pushes; read back through port
        step(3, 0, 0, 1, 0, 16'h0, 4'b1000, 4'h0, 16'hABCD);
        step(3, 0, 0, 1, 0, 16'h0, 4'b1000, 4'h0, 16'h1234);
        step(3, 1, 0, 1, 0, 16'h0, 4'h0, 4'h0, 16'h0);
        step(3, 0, 0, 0, 0, 16'h0, 4'h0, 4'h0, 16'h0);   // R9: OE off -> zero
        // R2: wrong-direction strobes ignored
        step(2, 0, 1, 1, 0, 16'hBEEF, 4'b0001, 4'b0100, 16'h5555);
        step(2, 0, 0, 0, 1, 16'h0, 4'h0, 4'h0, 16'h0);   // R10: commit on OUT does nothing
        // R3 R4: flip all polarities to active-high
        cfg_strobe_hi = 4'b1111;
        cfg_flag_hi   = 1'b1;
        for (int k = 0; k < 3; k++) step(1, 0, 1, 1, 0, 16'(16'h0F0 + k), 4'h0, 4'h0, 16'h0);
        step(1, 0, 0, 1, 1, 16'h0, 4'h0, 4'h0, 16'h0);   // R10: narrow count = bytes
        idle();

        // constrained random traffic
        for (int n = 0; n < 1600; n++) begin
            int a;
            if (n == 800) begin
                cfg_strobe_hi = 4'($urandom);
                cfg_flag_hi   = 1'($urandom);
            end
            a = int'($urandom % 4);
            step(a, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
                 ($urandom % 12) == 0, 16'($urandom), 4'($urandom) & 4'($urandom),
                 4'($urandom) & 4'($urandom), 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule